// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Threshold Mask and Deferred Scheduler Exception

This block collects interrupt requests from a set of sources and picks one winner to hand to a processor core. Each source has a 3-bit priority number. Lower numbers are more urgent, so 0 is the most urgent and 7 the least. A threshold register can block the less urgent levels. The threshold can be loaded freely through one write port, or only tightened through a second port. The block also keeps a nesting record of the handlers that are running. A request is granted only when it is more urgent than the handler currently active.

A software-set pending flag requests a scheduler exception that runs at the least urgent level. Because of that level, it runs only after every other handler has finished. If the flag is set again while the scheduler handler is running, its return chains straight back into it. The core reports handler completion on `exc_done`. The block then tells the core, on its sleep outputs, whether to drop to a light or deep sleep. It does this after the last handler returns, or when the core issues a wait-for-interrupt. Any pending enabled source wakes the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Among pending, enabled, unmasked sources, the one with the smallest priority number wins. Equal priorities go to the lowest source index. `exc_id` carries the source index, and the value NSRC means the scheduler exception.
- R2: When `base_mask` holds a nonzero value N, no request with a priority number of N or more is granted. A `base_mask` of 0 blocks nothing.
- R3: A raise-only write (`mask_raise`) loads `mask_wdata` only if the value is nonzero and either the mask is 0 or the value is below the current mask. Otherwise the mask is unchanged.
- R4: A plain write (`mask_set`) loads any value, including 0. When both write ports are pulsed in one cycle, the plain write wins.
- R5: A request preempts the running handler only if its priority number is strictly below the active level. An equal or larger number waits until the handlers above it return.
- R6: A `sched_set` pulse sets `sched_pend`. The scheduler exception is granted at priority 7, and only when no handler is active. Entry clears `sched_pend`, unless `sched_set` is pulsed in the same cycle as the entry.
- R7: If `sched_pend` is set when the running scheduler handler returns, the return edge grants the scheduler exception again, and `in_handler` never drops.
- R8: With `sleep_on_exit` high, a return that leaves no handler active and nothing pending raises a sleep request. With `sleep_on_exit` low, no sleep request is raised.
- R9: A `wfi` pulse raises `deep_req` when `deep_sel` is 1, or `sleep_req` when it is 0, and the request stays up. A pending enabled source clears it on the next edge, even when the mask blocks that source. A disabled source does not clear it.
- R10: A request sampled at one edge becomes pending at that edge and is granted at the next, with `exc_take` high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Per-source request, sampled each edge |
| irq_en | input | NSRC | Per-source enable |
| irq_prio | input | NSRC*PW | Packed per-source priority, source i at bits [i*PW +: PW] |
| mask_set | input | 1 | Plain write of the threshold |
| mask_raise | input | 1 | Raise-only write of the threshold |
| mask_wdata | input | PW | Threshold write data |
| sched_set | input | 1 | Sets the scheduler pending flag |
| exc_done | input | 1 | Core reports return from the active handler |
| wfi | input | 1 | Wait-for-interrupt request |
| sleep_on_exit | input | 1 | Sleep after the last handler returns |
| deep_sel | input | 1 | Selects deep sleep instead of light sleep |
| exc_take | output | 1 | One-cycle grant of an exception |
| exc_id | output | IW | Granted source index, NSRC for the scheduler |
| exc_prio | output | PW | Priority of the granted exception |
| in_handler | output | 1 | At least one handler is active |
| base_mask | output | PW | Current threshold |
| sched_pend | output | 1 | Scheduler pending flag |
| sleep_req | output | 1 | Light sleep request |
| deep_req | output | 1 | Deep sleep request |

## Verification
The return of a handler and the grant of a new exception can happen on the same edge. The bench provokes this in three ways. It chains from one source to a pending equal-priority source. It re-enters the scheduler while `sched_pend` is set. It pulses `sched_set` in the very cycle the scheduler is entered. In each case the bench requires `exc_take` on the return edge with `in_handler` held high, and it requires the pending flag to match the same-cycle rule.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 4,
  parameter int PW   = 3,
  localparam int LV  = 1 << PW,
  localparam int IW  = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    irq_req,
  input  logic [NSRC-1:0]    irq_en,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic               mask_set,
  input  logic               mask_raise,
  input  logic [PW-1:0]      mask_wdata,
  input  logic               sched_set,
  input  logic               exc_done,
  input  logic               wfi,
  input  logic               sleep_on_exit,
  input  logic               deep_sel,
  output logic               exc_take,
  output logic [IW-1:0]      exc_id,
  output logic [PW-1:0]      exc_prio,
  output logic               in_handler,
  output logic [PW-1:0]      base_mask,
  output logic               sched_pend,
  output logic               sleep_req,
  output logic               deep_req
);

  logic [NSRC-1:0] pend, clr;
  logic [LV-1:0]   act, eff_act;
  logic [PW:0]     eff_lvl;
  logic            win_ok, take, wake, exit_sleep, sleep_q;
  logic [IW-1:0]   win_id;
  logic [PW-1:0]   win_prio;

  function automatic logic blocked(input logic [PW-1:0] p, input logic [PW-1:0] m);
    return (m != '0) && (p >= m);
  endfunction

  always_comb begin
    logic [PW-1:0] p;
    win_ok = 1'b0;
    win_id = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      p = irq_prio[i*PW +: PW];
      if (pend[i] && irq_en[i] && !blocked(p, base_mask) && (!win_ok || p < win_prio)) begin
        win_ok = 1'b1;
        win_id = IW'(i);
        win_prio = p;
      end
    end
    if (!win_ok && sched_pend && !blocked(PW'(LV - 1), base_mask)) begin
      win_ok = 1'b1;
      win_id = IW'(NSRC);
      win_prio = PW'(LV - 1);
    end
  end

  assign eff_act = (exc_done && |act) ? (act & (act - 1'b1)) : act;

  always_comb begin
    eff_lvl = (PW+1)'(LV);
    for (int k = LV - 1; k >= 0; k--)
      if (eff_act[k]) eff_lvl = (PW+1)'(k);
  end

  assign take = win_ok && ({1'b0, win_prio} < eff_lvl);

  always_comb
    for (int i = 0; i < NSRC; i++)
      clr[i] = take && (win_id == IW'(i));

  assign wake       = |(pend & irq_en) || sched_pend;
  assign exit_sleep = sleep_on_exit && exc_done && |act && (eff_act == '0) && !take;
  assign in_handler = |act;
  assign sleep_req  = sleep_q && !deep_sel;
  assign deep_req   = sleep_q && deep_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= '0;
      act        <= '0;
      sched_pend <= 1'b0;
      base_mask  <= '0;
      sleep_q    <= 1'b0;
      exc_take   <= 1'b0;
      exc_id     <= '0;
      exc_prio   <= '0;
    end else begin
      pend       <= (pend & ~clr) | irq_req;
      act        <= eff_act | (take ? (LV'(1) << win_prio) : '0);
      sched_pend <= sched_set || (sched_pend && !(take && win_id == IW'(NSRC)));
      exc_take   <= take;
      if (take) begin
        exc_id   <= win_id;
        exc_prio <= win_prio;
      end
      if (mask_set)
        base_mask <= mask_wdata;
      else if (mask_raise && mask_wdata != '0 && (base_mask == '0 || mask_wdata < base_mask))
        base_mask <= mask_wdata;
      if (wake)
        sleep_q <= 1'b0;
      else if (wfi || exit_sleep)
        sleep_q <= 1'b1;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 4,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mask_set,
  input logic          sched_set,
  input logic          exc_take,
  input logic [IW-1:0] exc_id,
  input logic [PW-1:0] exc_prio,
  input logic          in_handler,
  input logic [PW-1:0] base_mask,
  input logic          sched_pend,
  input logic          sleep_req,
  input logic          deep_req
);

  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> ($past(base_mask) == '0 || exc_prio < $past(base_mask))); // R2

  AST_MASK_NEVER_WEAKENS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_set |=> (base_mask == $past(base_mask) ||
                   (base_mask != '0 && ($past(base_mask) == '0 || base_mask < $past(base_mask))))); // R3

  AST_SCHED_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_id == IW'(NSRC)) |-> (!sched_pend || $past(sched_set))); // R6

  AST_SCHED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_id == IW'(NSRC)) |-> exc_prio == PW'((1 << PW) - 1)); // R6

  AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> in_handler); // R10

  AST_ONE_SLEEP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_req, deep_req})); // R9

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_set(mask_set), .sched_set(sched_set),
  .exc_take(exc_take), .exc_id(exc_id), .exc_prio(exc_prio),
  .in_handler(in_handler), .base_mask(base_mask), .sched_pend(sched_pend),
  .sleep_req(sleep_req), .deep_req(deep_req)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NSRC = 4;
  localparam int PW   = 3;
  localparam int IW   = $clog2(NSRC + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '1;
  logic [NSRC*PW-1:0] irq_prio;
  logic mask_set = 0, mask_raise = 0, sched_set = 0, exc_done = 0, wfi = 0;
  logic sleep_on_exit = 0, deep_sel = 0;
  logic [PW-1:0] mask_wdata = '0;
  logic exc_take, in_handler, sched_pend, sleep_req, deep_req;
  logic [IW-1:0] exc_id;
  logic [PW-1:0] exc_prio, base_mask;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .PW(PW)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask
  task automatic pulse(input logic [NSRC-1:0] m); irq_req = m; step(); irq_req = '0; endtask
  task automatic ret(); exc_done = 1; step(); exc_done = 0; endtask
  task automatic setm(input logic p, input logic r, input int v);
    mask_set = p; mask_raise = r; mask_wdata = PW'(v); step(); mask_set = 0; mask_raise = 0;
  endtask
  task automatic set_prio(input int s, input int p); irq_prio[s*PW +: PW] = PW'(p); endtask

  task automatic t_reset();
    chk("R10 reset take", exc_take, 0);
    chk("R10 reset in_handler", in_handler, 0);
    chk("R2 reset mask", base_mask, 0);
    chk("R9 reset sleep", {sleep_req, deep_req}, 0);
  endtask

  task automatic t_tie();
    pulse(4'b1110);
    step();
    chk("R10 grant after one edge", exc_take, 1);
    chk("R1 tie to lowest index", exc_id, 1);
    ret();
    chk("R1 chained equal prio id", exc_id, 2);
    chk("R1 chained take", exc_take, 1);
    ret();
    chk("R1 next prio id", exc_id, 3);
    chk("R1 next prio value", exc_prio, 5);
    ret();
    chk("R1 back to thread", in_handler, 0);
  endtask

  task automatic t_mask();
    setm(1, 0, 4); chk("R4 plain load", base_mask, 4);
    setm(0, 1, 6); chk("R3 raise ignores weaker", base_mask, 4);
    setm(0, 1, 2); chk("R3 raise tightens", base_mask, 2);
    setm(0, 1, 0); chk("R3 raise ignores zero", base_mask, 2);
    setm(1, 1, 6); chk("R4 plain wins over raise", base_mask, 6);
    setm(1, 0, 0); chk("R4 plain clears", base_mask, 0);
    setm(1, 0, 3);
    pulse(4'b1000);
    step();
    chk("R2 masked not granted", exc_take, 0);
    chk("R2 masked stays in thread", in_handler, 0);
    setm(1, 0, 0);
    step();
    chk("R2 unmasked granted", exc_id, 3);
    ret();
  endtask

  task automatic t_preempt();
    set_prio(0, 1);
    pulse(4'b0010); step();
    chk("R5 first grant", exc_id, 1);
    pulse(4'b0100); step();
    chk("R5 equal does not preempt", exc_take, 0);
    pulse(4'b0001); step();
    chk("R5 more urgent preempts", exc_id, 0);
    ret();
    chk("R5 equal still waits", exc_take, 0);
    chk("R5 outer handler active", in_handler, 1);
    ret();
    chk("R5 equal granted after return", exc_id, 2);
    ret();
    chk("R5 thread", in_handler, 0);
    set_prio(0, 3);
  endtask

  task automatic t_sched();
    pulse(4'b0010); step();
    sched_set = 1; step(); sched_set = 0;
    chk("R6 pending set", sched_pend, 1);
    step();
    chk("R6 waits behind handler", exc_take, 0);
    ret();
    chk("R6 granted id", exc_id, NSRC);
    chk("R6 granted prio", exc_prio, 7);
    chk("R6 cleared on entry", sched_pend, 0);
    sched_set = 1; step(); sched_set = 0;
    ret();
    chk("R7 re-entry take", exc_take, 1);
    chk("R7 re-entry id", exc_id, NSRC);
    chk("R7 stays in handler", in_handler, 1);
    ret();
    chk("R7 thread", in_handler, 0);
    sched_set = 1; step();
    step(); sched_set = 0;
    chk("R6 same-cycle entry take", exc_take, 1);
    chk("R6 same-cycle set keeps pending", sched_pend, 1);
    ret();
    chk("R7 re-entry after same-cycle", exc_take, 1);
    chk("R6 cleared second entry", sched_pend, 0);
    ret();
  endtask

  task automatic t_sleep();
    sleep_on_exit = 1;
    pulse(4'b1000); step();
    ret();
    chk("R8 sleep after last return", sleep_req, 1);
    chk("R8 thread", in_handler, 0);
    pulse(4'b0010); step();
    chk("R8 wake clears sleep", sleep_req, 0);
    chk("R8 wake grant", exc_id, 1);
    sleep_on_exit = 0;
    ret();
    chk("R8 no sleep when disabled", sleep_req, 0);
  endtask

  task automatic t_wfi();
    deep_sel = 1;
    wfi = 1; step(); wfi = 0;
    chk("R9 deep request", deep_req, 1);
    chk("R9 light off", sleep_req, 0);
    setm(1, 0, 1);
    chk("R9 deep holds", deep_req, 1);
    pulse(4'b0100); step();
    chk("R9 masked source wakes", deep_req, 0);
    chk("R9 masked not granted", exc_take, 0);
    setm(1, 0, 0);
    step();
    chk("R9 granted after unmask", exc_id, 2);
    ret();
    irq_en[3] = 0;
    wfi = 1; step(); wfi = 0;
    pulse(4'b1000); step();
    chk("R9 disabled source does not wake", deep_req, 1);
    irq_en[3] = 1; step();
    chk("R9 enable wakes", deep_req, 0);
    chk("R9 enable grants", exc_id, 3);
    ret();
    deep_sel = 0;
    wfi = 1; step(); wfi = 0;
    chk("R9 light request", sleep_req, 1);
    pulse(4'b0001); step();
    chk("R9 light wakes", sleep_req, 0);
    ret();
  endtask

  initial begin
    irq_prio = '0;
    set_prio(0, 3); set_prio(1, 2); set_prio(2, 2); set_prio(3, 5);
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_tie();
    t_mask();
    t_preempt();
    t_sched();
    t_sleep();
    t_wfi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule